// File: doc/BRIEF.md
# Cycle-Relative Output Window Generator

This block drives a set of digital output lines, each of which is high during a programmable window inside a repeating cycle. A controller outside the block owns the cycle. It raises a one-tick strobe at the start of every cycle and supplies a phase count that starts at zero on the strobe tick and advances by one per coarse clock tick. Every channel has a 32-bit timing word that holds a start tick and a stop tick. A shared cycle-length value clips every window so that no pulse runs past the end of the cycle.

On each strobe the block copies the timing words and the cycle length into held copies. Software can therefore rewrite them during a cycle without tearing the pulse that is already in progress. While the controller's run enable is low, all outputs are held low. After the enable returns, the outputs stay low until the next strobe. Output resolution is one coarse tick.

Top module: `owg_window_gen`

## Requirements
- R1: After reset, and after any enabled period that has not yet seen a strobe, every output is low.
- R2: Channel i's timing word occupies bits [32*i+31 : 32*i] of the word bus. Inside a word, the stop tick sits in bits [31:16] and the start tick sits in bits [15:0].
- R3: Output i is high exactly when start <= phase < stop. It appears one clock after the phase value that produces it.
- R4: When stop exceeds the cycle length, the pulse ends at phase = cycle length.
- R5: When start is greater than or equal to the cycle length, the channel produces no pulse in that cycle.
- R6: When start is greater than or equal to stop, the channel stays low.
- R7: While run enable is low, all outputs are low one clock later. Raising run enable again produces no pulse until a strobe arrives.
- R8: Timing words and cycle length take effect at the strobe tick. Changes made between strobes act only from the next strobe onward.
- R9: Channels are independent: each channel's output depends only on its own word, the shared length, the strobe, the phase and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Controller running; low forces all outputs low |
| cyc_start | input | 1 | One-tick strobe at the start of each cycle |
| cyc_phase | input | TW | Ticks since the cycle strobe (0 on the strobe tick) |
| cyc_len | input | TW | Cycle length in ticks, sampled on the strobe |
| win_words | input | 32*NCH | Packed per-channel timing words |
| win_out | output | NCH | Per-channel window outputs |

## Verification
Each output answers the strobe, phase, enable and words that were present on the previous rising edge. The result is therefore due exactly one clock after the stimulus. The bench changes inputs on the falling edge and compares outputs on the following falling edge, against an expectation computed from the values it drove just before. New words and lengths count from the strobe tick itself, so a reference model in the bench holds its own copies and swaps them on the same tick as the strobe. Mid-cycle rewrites and enable drops are placed at chosen phases so that the one-clock latency separates old behaviour from new.

// File: rtl/owg_pkg.sv
package owg_pkg;
   localparam int WORD_W  = 32;
   localparam int FIELD_W = 16;

   // Per-channel timing word; stop in the upper half, start in the lower half.
   typedef struct packed {
      logic [FIELD_W-1:0] stop;
      logic [FIELD_W-1:0] start;
   } owg_word_t;
endpackage

// File: rtl/owg_window.sv
// Combinational window test for one channel.
module owg_window #(
   parameter int TW = 16
) (
   input  logic [TW-1:0] phase,
   input  logic [TW-1:0] start,
   input  logic [TW-1:0] stop,
   input  logic [TW-1:0] len,
   output logic          hit
);
   logic [TW-1:0] end_tick;

   // Clip the window end against the cycle length (R4); a start at or past
   // the length can then never satisfy phase >= start && phase < end (R5).
   always_comb begin
      end_tick = (stop < len) ? stop : len;
      hit      = (phase >= start) && (phase < end_tick);
   end
endmodule

// File: rtl/owg_shadow.sv
// Holds per-cycle copies of timing words and cycle length, loaded on the strobe.
module owg_shadow
   import owg_pkg::*;
#(
   parameter int NCH = 4,
   parameter int TW  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [NCH*WORD_W-1:0] live_words,
   input  logic [TW-1:0]         live_len,
   output logic [NCH*TW-1:0]     eff_start,
   output logic [NCH*TW-1:0]     eff_stop,
   output logic [TW-1:0]         eff_len,
   output logic [NCH*TW-1:0]     held_start,
   output logic [NCH*TW-1:0]     held_stop,
   output logic [TW-1:0]         held_len
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_len <= '0;
      else if (load) held_len <= live_len;
   end

   assign eff_len = load ? live_len : held_len;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      owg_word_t     w;
      logic [TW-1:0] w_start;
      logic [TW-1:0] w_stop;

      assign w       = live_words[i*WORD_W +: WORD_W];
      assign w_start = w.start[TW-1:0];
      assign w_stop  = w.stop[TW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_start[i*TW +: TW] <= '0;
            held_stop[i*TW +: TW]  <= '0;
         end else if (load) begin
            held_start[i*TW +: TW] <= w_start;
            held_stop[i*TW +: TW]  <= w_stop;
         end
      end

      // On the strobe tick the fresh values apply at once (R8).
      assign eff_start[i*TW +: TW] = load ? w_start : held_start[i*TW +: TW];
      assign eff_stop[i*TW +: TW]  = load ? w_stop  : held_stop[i*TW +: TW];
   end
endmodule

// File: rtl/owg_outstage.sv
// Arming flag and output gating; OUT_REG selects registered or direct outputs.
module owg_outstage #(
   parameter int NCH     = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run_en,
   input  logic           cyc_start,
   input  logic [NCH-1:0] hit,
   output logic           armed,
   output logic [NCH-1:0] win_out
);
   logic           gate;
   logic [NCH-1:0] out_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed <= 1'b0;
      else if (!run_en)   armed <= 1'b0;
      else if (cyc_start) armed <= 1'b1;
   end

   always_comb begin
      gate  = run_en && (armed || cyc_start);
      out_d = gate ? hit : '0;
   end

   if (OUT_REG) begin : g_reg
      logic [NCH-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= '0;
         else        out_q <= out_d;
      end
      assign win_out = out_q;
   end else begin : g_comb
      assign win_out = out_d;
   end
endmodule

// File: rtl/owg_window_gen.sv
module owg_window_gen
   import owg_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int TW      = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_en,
   input  logic                  cyc_start,
   input  logic [TW-1:0]         cyc_phase,
   input  logic [TW-1:0]         cyc_len,
   input  logic [NCH*WORD_W-1:0] win_words,
   output logic [NCH-1:0]        win_out
);
   if (TW < 1 || TW > FIELD_W) begin : g_bad_tw
      $error("owg_window_gen: TW must lie in 1..16");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("owg_window_gen: NCH must be at least 1");
   end

   logic [NCH*TW-1:0] eff_start, eff_stop, held_start, held_stop;
   logic [TW-1:0]     eff_len, held_len;
   logic [NCH-1:0]    hit;
   logic              armed;

   owg_shadow #(.NCH(NCH), .TW(TW)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cyc_start),
      .live_words (win_words),
      .live_len   (cyc_len),
      .eff_start  (eff_start),
      .eff_stop   (eff_stop),
      .eff_len    (eff_len),
      .held_start (held_start),
      .held_stop  (held_stop),
      .held_len   (held_len)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_win
      owg_window #(.TW(TW)) u_win (
         .phase (cyc_phase),
         .start (eff_start[i*TW +: TW]),
         .stop  (eff_stop[i*TW +: TW]),
         .len   (eff_len),
         .hit   (hit[i])
      );
   end

   owg_outstage #(.NCH(NCH), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .cyc_start (cyc_start),
      .hit       (hit),
      .armed     (armed),
      .win_out   (win_out)
   );

   if (OUT_REG) begin : g_sva
      a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
         !run_en |=> (win_out == '0));
      a_r1_unarmed_low: assert property (@(posedge clk) disable iff (!rst_n)
         (!armed && !cyc_start) |=> (win_out == '0));
      a_r4_past_len_low: assert property (@(posedge clk) disable iff (!rst_n)
         (!cyc_start && cyc_phase >= held_len) |=> (win_out == '0));
      for (genvar i = 0; i < NCH; i++) begin : g_ch_sva
         a_r6_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start && held_start[i*TW +: TW] >= held_stop[i*TW +: TW])
               |=> !win_out[i]);
         a_r5_late_start: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start && held_start[i*TW +: TW] >= held_len) |=> !win_out[i]);
         a_r3_before_start: assert property (@(posedge clk) disable iff (!rst_n)
            (!cyc_start && cyc_phase < held_start[i*TW +: TW]) |=> !win_out[i]);
      end
   end
endmodule

// File: tb/test_owg_window_gen.sv
module test_owg_window_gen;
   localparam int NCH = 4;
   localparam int TW  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              run_en = 1'b0;
   logic              cyc_start = 1'b0;
   logic [TW-1:0]     cyc_phase = '0;
   logic [TW-1:0]     cyc_len = '0;
   logic [NCH*32-1:0] win_words;
   logic [NCH-1:0]    win_out;

   logic [15:0] b_start[NCH];
   logic [15:0] b_stop[NCH];
   logic [15:0] m_start[NCH];
   logic [15:0] m_stop[NCH];
   logic [15:0] m_len;
   logic        m_armed;
   logic [NCH-1:0] exp_out;
   int    checks = 0;
   int    fails = 0;
   string tag = "R1";

   always #5 clk = ~clk;

   // R2: packing of stop/start and channel placement on the word bus.
   always_comb begin
      for (int i = 0; i < NCH; i++) win_words[i*32 +: 32] = {b_stop[i], b_start[i]};
   end

   owg_window_gen #(.NCH(NCH), .TW(TW)) i_owg_window_gen (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cyc_start(cyc_start),
      .cyc_phase(cyc_phase), .cyc_len(cyc_len), .win_words(win_words),
      .win_out(win_out)
   );

   task automatic check(input logic [NCH-1:0] exp);
      checks++;
      if (win_out !== exp) begin
         fails++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, win_out, exp);
      end
   endtask

   task automatic set_ch(input int ch, input int s, input int e);
      b_start[ch] = s[15:0];
      b_stop[ch]  = e[15:0];
   endtask

   // Drive one tick of stimulus, advance one clock, and compare.
   task automatic drive(input logic act, input logic cs, input int ph);
      logic [15:0] es, ee, el;
      run_en = act; cyc_start = cs; cyc_phase = ph[TW-1:0];
      el = cs ? cyc_len : m_len;
      for (int i = 0; i < NCH; i++) begin
         es = cs ? b_start[i] : m_start[i];
         ee = cs ? b_stop[i]  : m_stop[i];
         exp_out[i] = act && (cs || m_armed) && (ph[15:0] >= es) &&
                      (ph[15:0] < ee) && (ph[15:0] < el);
      end
      if (cs) begin
         m_len = cyc_len;
         for (int i = 0; i < NCH; i++) begin
            m_start[i] = b_start[i];
            m_stop[i] = b_stop[i];
         end
      end
      m_armed = !act ? 1'b0 : (cs ? 1'b1 : m_armed);
      @(negedge clk);
      check(exp_out);
   endtask

   task automatic run_cycle(input int len, input int ticks);
      cyc_len = len[TW-1:0];
      for (int t = 0; t < ticks; t++) drive(1'b1, t == 0, t);
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) begin
         b_start[i] = '0; b_stop[i] = '0; m_start[i] = '0; m_stop[i] = '0;
      end
      m_len = '0; m_armed = 1'b0;
      void'($urandom(32'd20240611));
      // R1: outputs low during reset
      repeat (3) @(negedge clk);
      tag = "R1"; check('0);
      rst_n = 1'b1;
      // R1: enabled but no strobe yet
      set_ch(0, 0, 10); set_ch(1, 2, 5);
      cyc_len = 16'd20;
      for (int t = 0; t < 8; t++) drive(1'b1, 1'b0, t);

      // R3 / R2: basic windows on distinct channels
      tag = "R3";
      set_ch(0, 3, 7); set_ch(1, 0, 1); set_ch(2, 5, 12); set_ch(3, 10, 11);
      run_cycle(20, 22);
      run_cycle(20, 22);

      // R4: stop past length clipped
      tag = "R4";
      set_ch(0, 2, 30); set_ch(1, 0, 100); set_ch(2, 9, 10); set_ch(3, 0, 10);
      run_cycle(10, 14);

      // R5: start at or past length
      tag = "R5";
      set_ch(0, 10, 20); set_ch(1, 12, 40); set_ch(2, 9, 40); set_ch(3, 0, 3);
      run_cycle(10, 14);

      // R6: empty windows
      tag = "R6";
      set_ch(0, 5, 5); set_ch(1, 8, 2); set_ch(2, 1, 0); set_ch(3, 4, 6);
      run_cycle(20, 22);

      // R7: enable drop mid-cycle, re-enable without strobe
      tag = "R7";
      set_ch(0, 0, 25); set_ch(1, 3, 25); set_ch(2, 0, 25); set_ch(3, 6, 9);
      cyc_len = 16'd30;
      for (int t = 0; t < 10; t++) drive(1'b1, t == 0, t);
      for (int t = 10; t < 13; t++) drive(1'b0, 1'b0, t);
      for (int t = 13; t < 20; t++) drive(1'b1, 1'b0, t);
      run_cycle(30, 8);

      // R8: mid-cycle rewrite of words and length acts only after next strobe
      tag = "R8";
      set_ch(0, 3, 9); set_ch(1, 0, 4); set_ch(2, 6, 8); set_ch(3, 1, 15);
      cyc_len = 16'd16;
      for (int t = 0; t < 5; t++) drive(1'b1, t == 0, t);
      set_ch(0, 0, 2); set_ch(1, 5, 14); set_ch(2, 0, 16); set_ch(3, 20, 21);
      cyc_len = 16'd4;
      for (int t = 5; t < 18; t++) drive(1'b1, 1'b0, t);
      run_cycle(4, 8);

      // R9: random independent channels, with mid-cycle rewrites and drops
      tag = "R9";
      for (int c = 0; c < 300; c++) begin
         int len, ticks, chg;
         for (int i = 0; i < NCH; i++) set_ch(i, $urandom_range(0, 40), $urandom_range(0, 45));
         len = $urandom_range(1, 40);
         ticks = len + $urandom_range(0, 6);
         chg = $urandom_range(1, ticks + 10);
         cyc_len = len[TW-1:0];
         for (int t = 0; t < ticks; t++) begin
            if (t == chg) begin
               for (int i = 0; i < NCH; i++) set_ch(i, $urandom_range(0, 40), $urandom_range(0, 45));
               cyc_len = 16'($urandom_range(1, 40));
            end
            drive(($urandom_range(0, 19) != 0), t == 0, t);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule